// File: doc/BRIEF.md
# Escaped Extraction Word Encoder

The encoder turns a stream of queued frame words into the 32-bit word sequence that a host collects by repeatedly reading one register. Frame boundaries and frame status travel in-band as reserved code words. The host never sees a separate sideband. A reserved code has 0x80 in its low byte, a 3-bit code in bits 26:24, and zeros in every other bit.

When a frame ends, the encoder emits an end code just before the last word. That code gives either the number of unused bytes in the last word or a pruned marker. A frame that is cut short yields an abort code, and the rest of that frame is dropped. A data word that would look like a reserved code is sent behind an escape prefix. A read made while nothing is pending returns a not-ready code and changes nothing. A data-present flag tells the host when reading is worthwhile.

Frames enter through a valid/ready word interface, one word per handshake. A flush input empties the encoder while it is held high. A byte-order control reverses the bytes of each data word before it is encoded.

Top module: `xtr_word_encoder`

## Requirements
- R1: Every reserved word has the form {5'b0, code[2:0], 16'h0000, 8'h80}. Code 5 means abort, 6 means escape and 7 means not ready.
- R2: An input word flagged last is preceded on the output by the reserved word whose code equals its in_unused value (0 to 3 unused bytes, so 4 minus code valid bytes).
- R3: A last word that also has in_pruned set is preceded by code 4 instead of its unused count.
- R4: A data word that equals any reserved word after byte ordering is emitted as 0x06000080 followed by the literal word. This includes a last word, where the escape comes after the end code.
- R5: A read strobe while data_present is low returns 0x07000080 and does not advance the stream.
- R6: data_present is high exactly when an output word is pending and flush is low.
- R7: An input word with in_abort set is replaced by 0x05000080. The following words of that frame, up to and including the one flagged last, are dropped.
- R8: While flush is high, data_present is low, rd_data is 0x07000080, in_ready is high and input words are dropped. Pending content is discarded, and words arriving after flush clears are encoded normally.
- R9: With cfg_swap high, each data word is emitted with its four bytes reversed, and reserved codes are unchanged. With cfg_swap low, data words pass unchanged. cfg_swap is only changed while nothing is pending.
- R10: rd_data holds the next word to be read. Each read strobe consumes exactly one word, and without a strobe rd_data stays stable while data is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_swap | input | 1 | Reverse byte order of data words |
| flush | input | 1 | Drop pending and incoming words while high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Word is the last of its frame |
| in_unused | input | 2 | Unused bytes in a last word |
| in_pruned | input | 1 | Last word ends a pruned frame |
| in_abort | input | 1 | Frame is aborted at this word |
| rd_stb | input | 1 | Host read strobe, consumes rd_data |
| rd_data | output | 32 | Word returned to the host |
| data_present | output | 1 | A word is pending for the host |

## Verification
A wrong phase in the sequencer shows on the very next read. Such a fault duplicates or skips an escape or end code, or it lets a literal slip out unescaped, and every strobe is compared against a reference word list. A stale discard flag appears as missing words at the start of the following frame. A hold register that changes without a strobe breaks the stability comparison within one cycle. Stimulus mixes random colliding words, aborts, pruned ends and both byte orders with directed flush and idle-read cases.

// File: rtl/xtr_enc_pkg.sv
package xtr_enc_pkg;
  localparam int WORD_W   = 32;
  localparam int N_BYTES  = WORD_W / 8;
  localparam int CODE_LSB = 24;
  localparam int CODE_W   = 3;
  localparam logic [7:0] MARK_BYTE = 8'h80;

  localparam logic [CODE_W-1:0] C_PRUNED = 3'd4;
  localparam logic [CODE_W-1:0] C_ABORT  = 3'd5;
  localparam logic [CODE_W-1:0] C_ESC    = 3'd6;
  localparam logic [CODE_W-1:0] C_IDLE   = 3'd7;

  typedef enum logic [1:0] {PH_CODE, PH_ESC, PH_DATA} phase_e;

  function automatic logic [WORD_W-1:0] code_word(input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[7:0] = MARK_BYTE;
    w[CODE_LSB +: CODE_W] = c;
    return w;
  endfunction
endpackage

// File: rtl/xtr_byte_order.sv
module xtr_byte_order #(
  parameter int N_BYTES = 4
) (
  input  logic                 en,
  input  logic [N_BYTES*8-1:0] din,
  output logic [N_BYTES*8-1:0] dout
);
  logic [N_BYTES*8-1:0] rev;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign rev[b*8 +: 8] = din[(N_BYTES-1-b)*8 +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/xtr_code_match.sv
module xtr_code_match
  import xtr_enc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              hit
);
  localparam int HI_LSB = CODE_LSB + CODE_W;

  always_comb begin
    hit = (word[7:0] == MARK_BYTE) &&
          (word[CODE_LSB-1:8] == '0) &&
          (word[WORD_W-1:HI_LSB] == '0);
  end
endmodule

// File: rtl/xtr_word_seq.sv
module xtr_word_seq
  import xtr_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_hit,
  input  logic              in_last,
  input  logic [1:0]        in_unused,
  input  logic              in_pruned,
  input  logic              in_abort,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] out_word,
  output logic              pending
);
  phase_e            phase_q, phase_d;
  logic              hold_v_q, hold_v_d;
  logic              discard_q, discard_d;
  logic [WORD_W-1:0] data_q;
  logic              hit_q, last_q, pruned_q, abort_q;
  logic [1:0]        unused_q;

  logic   final_ph, consume, load;
  phase_e init_ph;

  assign final_ph = (phase_q == PH_DATA) || (phase_q == PH_CODE && abort_q);
  assign consume  = hold_v_q && rd_stb && !flush;
  assign in_ready = flush || discard_q || !hold_v_q || (consume && final_ph);
  assign load     = in_valid && in_ready && !flush && !discard_q;

  always_comb begin
    if (in_abort || in_last) init_ph = PH_CODE;
    else if (in_hit)         init_ph = PH_ESC;
    else                     init_ph = PH_DATA;
  end

  // next state
  always_comb begin
    hold_v_d  = hold_v_q;
    phase_d   = phase_q;
    discard_d = discard_q;
    if (flush) begin
      hold_v_d  = 1'b0;
      discard_d = 1'b0;
    end else begin
      if (discard_q && in_valid && in_last) discard_d = 1'b0;
      if (load) begin
        hold_v_d = 1'b1;
        phase_d  = init_ph;
        if (in_abort && !in_last) discard_d = 1'b1;
      end else if (consume) begin
        if (final_ph)               hold_v_d = 1'b0;
        else if (phase_q == PH_CODE) phase_d = hit_q ? PH_ESC : PH_DATA;
        else                         phase_d = PH_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q  <= 1'b0;
      phase_q   <= PH_DATA;
      discard_q <= 1'b0;
    end else begin
      hold_v_q  <= hold_v_d;
      phase_q   <= phase_d;
      discard_q <= discard_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      hit_q    <= 1'b0;
      last_q   <= 1'b0;
      pruned_q <= 1'b0;
      abort_q  <= 1'b0;
      unused_q <= '0;
    end else if (load) begin
      data_q   <= in_word;
      hit_q    <= in_hit;
      last_q   <= in_last;
      pruned_q <= in_pruned;
      abort_q  <= in_abort;
      unused_q <= in_unused;
    end
  end

  // output word
  always_comb begin
    if (!hold_v_q || flush) begin
      out_word = code_word(C_IDLE);
    end else begin
      unique case (phase_q)
        PH_CODE: begin
          if (abort_q)       out_word = code_word(C_ABORT);
          else if (pruned_q) out_word = code_word(C_PRUNED);
          else               out_word = code_word({1'b0, unused_q});
        end
        PH_ESC:  out_word = code_word(C_ESC);
        default: out_word = data_q;
      endcase
    end
  end

  assign pending = hold_v_q && !flush;

  // R4: an escape read is always followed by the literal of the same word
  assert_esc_literal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && !flush && phase_q == PH_ESC && rd_stb)
      |=> (hold_v_q && phase_q == PH_DATA && $stable(data_q)));

  // R10: without a strobe the pending word does not move
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && !rd_stb && !flush)
      |=> (hold_v_q && $stable(data_q) && $stable(phase_q)));

  // R8: flush empties both the hold register and the discard state
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!hold_v_q && !discard_q));

  // R7: while the tail of an aborted frame is dropped, input is never stalled
  assert_discard_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    discard_q |-> in_ready);
endmodule

// File: rtl/xtr_word_encoder.sv
module xtr_word_encoder
  import xtr_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_swap,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [1:0]        in_unused,
  input  logic              in_pruned,
  input  logic              in_abort,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              data_present
);
  logic [WORD_W-1:0] ordered;
  logic              collide;

  xtr_byte_order #(.N_BYTES(N_BYTES)) u_order (
    .en   (cfg_swap),
    .din  (in_data),
    .dout (ordered)
  );

  xtr_code_match u_match (
    .word (ordered),
    .hit  (collide)
  );

  xtr_word_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (ordered),
    .in_hit    (collide),
    .in_last   (in_last),
    .in_unused (in_unused),
    .in_pruned (in_pruned),
    .in_abort  (in_abort),
    .rd_stb    (rd_stb),
    .out_word  (rd_data),
    .pending   (data_present)
  );

  // R5: an idle read with no new input leaves the encoder empty
  assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !data_present && !in_valid) |=> !data_present);

  // R6: flush always hides pending data from the host
  assert_flush_hides_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !data_present);
endmodule

// File: tb/xtr_word_encoder_bench.sv
module xtr_word_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] W_IDLE  = 32'h07000080;
  localparam logic [31:0] W_ESC   = 32'h06000080;
  localparam logic [31:0] W_ABORT = 32'h05000080;

  logic        clk, rst_n, cfg_swap, flush, in_valid, in_ready;
  logic [31:0] in_data, rd_data;
  logic        in_last, in_pruned, in_abort, rd_stb, data_present;
  logic [1:0]  in_unused;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] q_data[$];
  logic        q_last[$], q_pruned[$], q_abort[$];
  logic [1:0]  q_unused[$];
  logic [31:0] exp_q[$];
  bit          skip_frame;
  bit          cur_swap;

  xtr_word_encoder u_xtr_word_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_swap(cfg_swap), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_unused(in_unused), .in_pruned(in_pruned),
    .in_abort(in_abort), .rd_stb(rd_stb), .rd_data(rd_data),
    .data_present(data_present)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rcode(input logic [2:0] c);
    return {5'b0, c, 16'h0000, 8'h80};
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic bit is_res(input logic [31:0] w);
    return (w[7:0] == 8'h80) && (w[23:8] == 16'h0) && (w[31:27] == 5'h0);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // appends an input word and the output words it must produce
  task automatic add_word(input logic [31:0] d, input bit last, input logic [1:0] un,
                          input bit pr, input bit ab);
    logic [31:0] sw;
    q_data.push_back(d); q_last.push_back(last); q_unused.push_back(un);
    q_pruned.push_back(pr); q_abort.push_back(ab);
    if (skip_frame) begin
      if (last) skip_frame = 0;
      return;
    end
    if (ab) begin
      exp_q.push_back(W_ABORT);
      if (!last) skip_frame = 1;
      return;
    end
    if (last) exp_q.push_back(pr ? rcode(3'd4) : rcode({1'b0, un}));
    sw = cur_swap ? bswap(d) : d;
    if (is_res(sw)) exp_q.push_back(W_ESC);
    exp_q.push_back(sw);
  endtask

  task automatic gen_frames(input int nf, input bit with_abort, input bit with_prune);
    for (int f = 0; f < nf; f++) begin
      int len = 1 + ($urandom % 6);
      bit aborted = 0;
      for (int j = 0; j < len; j++) begin
        logic [31:0] d = $urandom;
        bit last = (j == len - 1);
        bit ab = 0;
        if ($urandom % 4 == 0) begin
          d = rcode(3'($urandom % 8));
          if (cur_swap) d = bswap(d);
        end
        if (with_abort && !aborted && ($urandom % 8 == 0)) begin ab = 1; aborted = 1; end
        add_word(d, last, 2'($urandom % 4), last && with_prune && ($urandom % 4 == 0), ab);
      end
    end
  endtask

  task automatic run_stream(input int rd_pct, input int vl_pct);
    int idx = 0;
    int guard = 0;
    bit prev_pres = 0, prev_rd = 0;
    logic [31:0] prev_data = '0;
    while ((idx < q_data.size() || exp_q.size() != 0) && guard < 20000) begin
      guard++;
      @(negedge clk);
      rd_stb   = (($urandom % 100) < rd_pct);
      in_valid = (idx < q_data.size()) && (($urandom % 100) < vl_pct);
      if (idx < q_data.size()) begin
        in_data = q_data[idx]; in_last = q_last[idx]; in_unused = q_unused[idx];
        in_pruned = q_pruned[idx]; in_abort = q_abort[idx];
      end
      #1;
      if (prev_pres && !prev_rd && data_present)
        check(rd_data == prev_data, "R10 stable", rd_data, prev_data);
      if (rd_stb) begin
        if (data_present) begin
          logic [31:0] e = (exp_q.size() != 0) ? exp_q.pop_front() : W_IDLE;
          check(rd_data == e, "R1 R2 R3 R4 R7 R9 R10 word", rd_data, e);
        end else begin
          check(rd_data == W_IDLE, "R5 idle read", rd_data, W_IDLE);
        end
      end
      prev_pres = data_present; prev_rd = rd_stb; prev_data = rd_data;
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    rd_stb = 0; in_valid = 0;
    check(guard < 20000, "R10 stream drained", 32'(exp_q.size()), 0);
    q_data.delete(); q_last.delete(); q_unused.delete(); q_pruned.delete(); q_abort.delete();
    exp_q.delete(); skip_frame = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cfg_swap = 0; flush = 0; in_valid = 0; rd_stb = 0;
    in_data = '0; in_last = 0; in_unused = '0; in_pruned = 0; in_abort = 0;
    skip_frame = 0; cur_swap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(data_present == 0, "R6 reset empty", 32'(data_present), 0);
    check(rd_data == W_IDLE, "R5 reset idle code", rd_data, W_IDLE);
    check(in_ready == 1, "R6 reset ready", 32'(in_ready), 1);

    // directed: escape on last word after end code (R2, R4)
    add_word(W_ESC, 1, 2'd3, 0, 0);
    // directed: pruned last word (R3)
    add_word(32'h11223344, 0, 2'd0, 0, 0);
    add_word(32'haabbccdd, 1, 2'd1, 1, 0);
    // directed: abort on first word, rest dropped (R7)
    add_word(32'h01010101, 0, 2'd0, 0, 1);
    add_word(32'h02020202, 0, 2'd0, 0, 0);
    add_word(32'h03030303, 1, 2'd2, 0, 0);
    // directed: abort on last word (R7)
    add_word(32'h04040404, 1, 2'd0, 0, 1);
    add_word(32'h05050505, 1, 2'd0, 0, 0);
    run_stream(60, 70);

    gen_frames(60, 1, 1);
    run_stream(50, 60);
    gen_frames(60, 1, 1);
    run_stream(90, 30);

    // byte swap (R9)
    cfg_swap = 1; cur_swap = 1;
    add_word(32'h80000007, 1, 2'd0, 0, 0);
    add_word(32'h12345678, 1, 2'd2, 0, 0);
    gen_frames(60, 1, 1);
    run_stream(60, 60);
    cfg_swap = 0; cur_swap = 0;

    // flush (R8)
    @(negedge clk);
    in_valid = 1; in_data = 32'hdeadbeef; in_last = 0; in_abort = 0; in_pruned = 0;
    @(negedge clk);
    in_valid = 0;
    #1;
    check(data_present == 1, "R6 pending word", 32'(data_present), 1);
    flush = 1; in_valid = 1; in_data = 32'h55555555;
    #1;
    check(data_present == 0, "R8 flush hides", 32'(data_present), 0);
    check(rd_data == W_IDLE, "R8 flush idle code", rd_data, W_IDLE);
    check(in_ready == 1, "R8 flush ready", 32'(in_ready), 1);
    @(negedge clk);
    flush = 0; in_valid = 0;
    #1;
    check(data_present == 0, "R8 flushed empty", 32'(data_present), 0);
    add_word(32'h0badf00d, 1, 2'd0, 0, 0);
    gen_frames(20, 1, 0);
    run_stream(70, 70);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule